// File: doc/BRIEF.md
# Serial CRC-16 Remainder Engine

This block folds a serial bit stream into a 16-bit cyclic redundancy remainder for the generator x^16 + x^12 + x^5 + 1. One data bit is taken per clock whenever the bit-valid input is high. Bits arrive most significant first. The running remainder is always visible on the output, so a framer can read it after the last bit of a frame.

The register starts from a seed value set by a parameter, 16'hFFFF by default. Reset loads the seed. A one-cycle init pulse also loads it, which lets the next frame start without a full reset. The output is the raw register: it is not inverted and its bits are not reversed.

Internally, a control module turns reset, init and bit-valid into two strobes. The strobes are `load` and `step`. A datapath module holds the register and a Galois feedback network. In that network the feedback term reaches only bits 12, 5 and 0.

Top module: `crc16Serial`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register loads the seed (16'hFFFF by default). `crcOut` shows that value from the following cycle.
- R2: On an edge where `bitValid` is high and neither `rst` nor `initPulse` is high, the register takes one step. Let f = crcOut[15] XOR bitIn. The new value is (crcOut shifted left one place, with 0 entering bit 0) XOR (16'h1021 if f is 1, else 0).
- R3: On an edge where `bitValid`, `initPulse` and `rst` are all low, the register keeps its value, whatever `bitIn` is.
- R4: On an edge where `initPulse` is high, the register reloads the seed even if `bitValid` is also high. The data bit presented on that edge is dropped.
- R5: `rst` takes priority over `initPulse` and `bitValid` together.
- R6: `crcOut` is the register contents with no final XOR and no bit reversal. The nine ASCII bytes "123456789", each sent most significant bit first from the default seed, leave 16'h29B1.
- R7: Only next-state bits 12, 5 and 0 receive the feedback term f. Bit 0 becomes f itself. Every other bit n becomes bit n-1 of the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; loads the seed |
| initPulse | input | 1 | Reloads the seed between frames, active high |
| bitValid | input | 1 | Consume `bitIn` on this edge |
| bitIn | input | 1 | Serial data bit, MSB of each byte first |
| crcOut | output | 16 | Current remainder register |

## Verification
The known nine-byte check string pins the bit order, the seed and the absence of any output transform. A wrong tap, a reversed shift or an inverted output would each give a value other than 16'h29B1.

A long random stream with valid gaps is compared cycle by cycle against a plain shift-and-XOR model. This catches errors that appear only for particular feedback patterns, and any step that happens during a hold cycle.

Init pulses asserted together with valid, and a reset issued mid-frame, separate the correct priority order from an engine that lets a data bit slip through on a reload.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  // strobes from the control module to the datapath
  typedef struct packed {
    logic load;  // reload seed
    logic step;  // consume one data bit
  } crcStrobe_t;
endpackage

// File: rtl/crc16Ctrl.sv
module crc16Ctrl
  import crc16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       initPulse,
  input  logic       bitValid,
  output crcStrobe_t strobe
);
  // reset and init both reload; a reload suppresses the data step (R4, R5)
  always_comb begin
    strobe.load = rst | initPulse;
    strobe.step = bitValid & ~(rst | initPulse);
  end

  // R3: with no request at all, neither strobe is raised
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!initPulse && !bitValid) |-> (strobe == '0));
endmodule

// File: rtl/crc16Datapath.sv
module crc16Datapath
  import crc16_pkg::*;
#(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY  = 16'h1021,
  parameter logic [15:0] SEED  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  crcStrobe_t       strobe,
  input  logic             bitIn,
  output logic [CRC_W-1:0] crcOut
);
  localparam int MSB = CRC_W - 1;

  logic [CRC_W-1:0] crcQ;
  logic [CRC_W-1:0] crcNext;
  logic             feedBack;

  assign feedBack = crcQ[MSB] ^ bitIn;

  // Galois network: feedback only where the polynomial has a term
  for (genvar i = 0; i < CRC_W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign crcNext[0] = feedBack & POLY[0];
    end else if (POLY[i]) begin : g_xor
      assign crcNext[i] = crcQ[i-1] ^ feedBack;
    end else begin : g_copy
      assign crcNext[i] = crcQ[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.load)      crcQ <= SEED[CRC_W-1:0];
    else if (strobe.step) crcQ <= crcNext;
  end

  assign crcOut = crcQ;

  // R3: register holds when no strobe
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.step) |=> $stable(crcOut));

  // R4: a reload lands the seed
  p_seed_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (crcOut == SEED[CRC_W-1:0]));

  // R2: bit 0 after a step is msb xor data
  p_lsb_fb_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> (crcOut[0] == ($past(crcOut[MSB]) ^ $past(bitIn))));

  // R7: bit 5 tapped, bit 13 plain copy
  p_tap5_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> (crcOut[5] == ($past(crcOut[4]) ^ $past(crcOut[MSB]) ^ $past(bitIn))));
  p_copy13_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.step |=> (crcOut[13] == $past(crcOut[12])));
endmodule

// File: rtl/crc16Serial.sv
module crc16Serial
  import crc16_pkg::*;
#(
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        initPulse,
  input  logic        bitValid,
  input  logic        bitIn,
  output logic [15:0] crcOut
);
  localparam int          CRC_W = 16;
  localparam logic [15:0] POLY  = 16'h1021;

  crcStrobe_t strobe;

  crc16Ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .initPulse (initPulse),
    .bitValid  (bitValid),
    .strobe    (strobe)
  );

  crc16Datapath #(
    .CRC_W (CRC_W),
    .POLY  (POLY),
    .SEED  (SEED)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .bitIn  (bitIn),
    .crcOut (crcOut)
  );
endmodule

// File: tb/tb_crc16Serial.sv
module tb_crc16Serial;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        initPulse = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic [15:0] crcOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] model = 16'hFFFF;

  always #2.5 clk = ~clk;  // 200 MHz

  crc16Serial dut (
    .clk(clk), .rst(rst), .initPulse(initPulse),
    .bitValid(bitValid), .bitIn(bitIn), .crcOut(crcOut)
  );

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (crcOut !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, crcOut, exp);
    end
  endtask

  // behavioural model: priority reset > init > valid
  function automatic logic [15:0] nextModel(logic [15:0] cur, logic r, logic ini,
                                            logic v, logic b);
    logic [15:0] t;
    if (r || ini) return 16'hFFFF;
    if (!v) return cur;
    t = cur << 1;
    if (cur[15] != b) t = t ^ 16'h1021;
    return t;
  endfunction

  // drive one cycle, then compare after the edge
  task automatic cyc(input logic r, input logic ini, input logic v, input logic b,
                     input string req);
    rst = r; initPulse = ini; bitValid = v; bitIn = b;
    @(posedge clk);
    #1;
    model = nextModel(model, r, ini, v, b);
    check(req, model);
  endtask

  task automatic sendByte(input logic [7:0] d);
    for (int k = 7; k >= 0; k--) cyc(0, 0, 1, d[k], "R2");
  endtask

  initial begin
    string msg = "123456789";
    @(negedge clk);
    cyc(1, 0, 0, 0, "R1");
    cyc(1, 0, 1, 1, "R1");
    check("R1", 16'hFFFF);

    // R7 single steps: msb=1,bit=1 -> no feedback; then bit 0 -> feedback
    cyc(0, 0, 1, 1, "R7");
    check("R7", 16'hFFFE);
    cyc(0, 0, 1, 0, "R7");
    check("R7", 16'hEFDD);

    // R3 hold with toggling data
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, k[0], "R3");
    check("R3", 16'hEFDD);

    // R4 init with valid drops bit
    cyc(0, 1, 1, 1, "R4");
    check("R4", 16'hFFFF);

    // R6 check string
    for (int j = 0; j < msg.len(); j++) sendByte(msg[j]);
    check("R6", 16'h29B1);

    // R5 reset beats init and valid mid-frame
    sendByte(8'hA5);
    cyc(1, 1, 1, 0, "R5");
    check("R5", 16'hFFFF);

    // random stream with gaps, occasional init
    for (int k = 0; k < 3000; k++) begin
      logic iv = ($urandom_range(0, 99) == 0);
      cyc(0, iv, ($urandom_range(0, 3) != 0), $urandom_range(0, 1), "R2");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule